// File: doc/BRIEF.md
# Inter-processor interrupt command unit

This block is the command-register pair through which software on one processor sends an interrupt message to another processor, or to every processor at once. Software first writes the destination identifier into the high command word. It then writes the low command word. That second write both holds the message fields and starts the send: the delivery mode, the vector (the start page for a startup message), the level and assert controls, and the broadcast shorthand.

A launched message is shown on a valid/ready output bundle and held there until the downstream side takes it. Until then, a read-only delivery-status bit in the low word stays at 1, and software polls it. Any write to the low word while a message is still pending is dropped, and a sticky error flag is raised. The destination is captured when the message launches, so software may load the next destination before the current message has been taken.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, msg_valid and cmd_err are 0 and both command words read back as zero.
- R2: A write to offset 0x310 stores the destination identifier from bits 31:24. A read of 0x310 returns that identifier in bits 31:24, with every other bit 0.
- R3: A write to offset 0x300 while nothing is pending launches a message, and msg_valid is 1 one cycle later. A read of 0x300 returns the vector in bits 7:0, the mode in bits 10:8, assert in bit 14, level in bit 15 and broadcast in bit 19. All other bits read 0, apart from bit 12.
- R4: The message carries the following fields:
  - the destination held in the high word at the moment of launch;
  - the mode (000 fixed, 101 INIT, 110 startup);
  - the vector, which for a startup message is the start page, that is, the entry address shifted right by 12;
  - the level and broadcast bits.
  
  A write to the high word while the message is pending does not change msg_dest.
- R5: When bit 19 was set, msg_bcast is 1 and msg_dest is 8'hFF, which addresses every unit including the sender.
- R6: With bit 15 = 1 (level-triggered), msg_assert equals bit 14. With bit 15 = 0 (edge-triggered), msg_assert is 1 whatever the value of bit 14.
- R7: While msg_valid is 1 and msg_ready is 0, msg_valid and all message fields hold steady. A clock edge with msg_valid and msg_ready both 1 completes delivery, and after that edge msg_valid is 0.
- R8: A write to 0x300 while a message is pending is ignored: the pending message and the low-word readback stay the same. The write sets cmd_err, and cmd_err stays 1 until reset.
- R9: Bit 12 of the low word reads 1 exactly while a message is pending. Software cannot write it: writing 1 there changes nothing, and it reads 0 once delivery completes.
- R10: Writes to any other offset change no state, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| msg_valid | output | 1 | Message pending on the output bundle |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_dest | output | 8 | Destination identifier (all ones on broadcast) |
| msg_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector, or start page for a startup message |
| msg_level | output | 1 | 1 = level-triggered |
| msg_assert | output | 1 | 1 = assert, 0 = deassert |
| msg_bcast | output | 1 | Broadcast to all units including the sender |
| cmd_err | output | 1 | Sticky error: a send was attempted while busy |

## Verification
A corrupted pending state shows at the ports within one cycle. A busy flag that clears early drops msg_valid before the handshake, or lets a second launch overwrite the fields in flight. A busy flag that sticks leaves bit 12 at 1 on the negedge after acceptance, and wrongly raises cmd_err on the next send. A wrong snapshot of the destination, or wrong field decoding, appears on the bundle in the first cycle of msg_valid, and again in the low-word readback at the same moment.

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOW_OFF  = 'h300,
  parameter logic [ADDR_W-1:0] HIGH_OFF = 'h310
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_dest,
  output logic [2:0]        msg_mode,
  output logic [7:0]        msg_vector,
  output logic              msg_level,
  output logic              msg_assert,
  output logic              msg_bcast,
  output logic              cmd_err
);
  localparam int BUSY_BIT  = 12;
  localparam int AST_BIT   = 14;
  localparam int LVL_BIT   = 15;
  localparam int BC_BIT    = 19;
  localparam logic [7:0] ALL_DEST = 8'hFF;

  logic [7:0] dest_q, snap_dest_q, vec_q;
  logic [2:0] mode_q;
  logic       lvl_q, ast_q, bc_q, busy_q, err_q;
  logic       wr_lo, wr_hi, launch, done;

  assign wr_lo  = bus_wr && (bus_addr == LOW_OFF);
  assign wr_hi  = bus_wr && (bus_addr == HIGH_OFF);
  assign launch = wr_lo && !busy_q;
  assign done   = busy_q && msg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q      <= '0;
      snap_dest_q <= '0;
      vec_q       <= '0;
      mode_q      <= '0;
      lvl_q       <= 1'b0;
      ast_q       <= 1'b0;
      bc_q        <= 1'b0;
      busy_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (wr_hi) dest_q <= bus_wdata[31:24];
      if (wr_lo && busy_q) err_q <= 1'b1;
      if (done) busy_q <= 1'b0;
      if (launch) begin
        busy_q      <= 1'b1;
        snap_dest_q <= dest_q;
        vec_q       <= bus_wdata[7:0];
        mode_q      <= bus_wdata[10:8];
        ast_q       <= bus_wdata[AST_BIT];
        lvl_q       <= bus_wdata[LVL_BIT];
        bc_q        <= bus_wdata[BC_BIT];
      end
    end
  end

  logic [31:0] lo_word;
  always_comb begin
    lo_word           = '0;
    lo_word[7:0]      = vec_q;
    lo_word[10:8]     = mode_q;
    lo_word[BUSY_BIT] = busy_q;
    lo_word[AST_BIT]  = ast_q;
    lo_word[LVL_BIT]  = lvl_q;
    lo_word[BC_BIT]   = bc_q;
  end

  assign bus_rdata  = (bus_addr == LOW_OFF)  ? lo_word :
                      (bus_addr == HIGH_OFF) ? {dest_q, 24'h0} : 32'h0;

  assign msg_valid  = busy_q;
  assign msg_dest   = bc_q ? ALL_DEST : snap_dest_q;
  assign msg_mode   = mode_q;
  assign msg_vector = vec_q;
  assign msg_level  = lvl_q;
  assign msg_assert = lvl_q ? ast_q : 1'b1;
  assign msg_bcast  = bc_q;
  assign cmd_err    = err_q;
endmodule

// File: rtl/ipi_cmd_unit_checker.sv
module ipi_cmd_unit_checker #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOW_OFF = 'h300
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_dest,
  input logic [2:0]        msg_mode,
  input logic [7:0]        msg_vector,
  input logic              msg_level,
  input logic              msg_assert,
  input logic              msg_bcast,
  input logic              cmd_err
);
  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == LOW_OFF && !msg_valid) |=> msg_valid);

  assert_bcast_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_bcast) |-> (msg_dest == 8'hFF));

  assert_edge_asserts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_level) |-> msg_assert);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) && $stable(msg_mode)
      && $stable(msg_vector) && $stable(msg_level) && $stable(msg_assert) && $stable(msg_bcast)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid);

  assert_busy_write_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == LOW_OFF && msg_valid) |=> cmd_err);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  assert_status_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == LOW_OFF) |-> (bus_rdata[12] == msg_valid));
endmodule

bind ipi_cmd_unit ipi_cmd_unit_checker #(.ADDR_W(ADDR_W), .LOW_OFF(LOW_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_mode(msg_mode),
  .msg_vector(msg_vector), .msg_level(msg_level), .msg_assert(msg_assert),
  .msg_bcast(msg_bcast), .cmd_err(cmd_err)
);

// File: tb/ipi_cmd_unit_bench.sv
`timescale 1ns/1ps
module ipi_cmd_unit_bench;
  localparam logic [11:0] LO = 12'h300;
  localparam logic [11:0] HI = 12'h310;
  localparam logic [31:0] JUNK = 32'hFFF7_2800;

  logic clk = 0, rst_n = 0, bus_wr = 0, msg_ready = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic msg_valid, msg_level, msg_assert, msg_bcast, cmd_err;
  logic [7:0] msg_dest, msg_vector;
  logic [2:0] msg_mode;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ipi_cmd_unit u_ipi_cmd_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_mode(msg_mode), .msg_vector(msg_vector), .msg_level(msg_level),
    .msg_assert(msg_assert), .msg_bcast(msg_bcast), .cmd_err(cmd_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  function automatic logic [31:0] bundle(input logic v, input logic [7:0] de, input logic [2:0] m,
      input logic [7:0] ve, input logic l, input logic as, input logic b);
    return {8'h0, v, de, m, ve, l, as, b};
  endfunction

  logic [31:0] act_b, exp_b, r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(!msg_valid && !cmd_err, "R1 idle after reset", {msg_valid, cmd_err}, 0);
    rd(LO, r); chk(r == 0, "R1 low word reset", r, 0);
    rd(HI, r); chk(r == 0, "R1 high word reset", r, 0);

    wr(HI, 32'hFFFF_FFFF);
    rd(HI, r); chk(r == 32'hFF00_0000, "R2 high word masking", r, 32'hFF00_0000);

    wr(12'h304, 32'h0000_4605);
    rd(12'h304, r); chk(r == 0, "R10 other offset reads 0", r, 0);
    chk(!msg_valid, "R10 other offset no launch", msg_valid, 0);
    rd(HI, r); chk(r == 32'hFF00_0000, "R10 high unchanged", r, 32'hFF00_0000);

    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 8; f++) begin
        logic lvl, ast, bc;
        logic [7:0] dst, vec, edst;
        logic [31:0] fields, wdat;
        int dly;
        lvl = f[0]; ast = f[1]; bc = f[2];
        dst = 8'(m * 16 + f + 1);
        vec = 8'((m * 37 + f * 11 + 5) & 8'hFF);
        dly = f % 3;
        fields = {12'h0, bc, 3'b0, lvl, ast, 1'b0, 1'b0, 1'b0, m[2:0], vec};
        wdat = fields | ((m % 2 == 1) ? JUNK : 32'h0) | ((f % 2 == 1) ? 32'h1000 : 32'h0);
        edst = bc ? 8'hFF : dst;
        wr(HI, {dst, 24'h5A5A5A});
        wr(LO, wdat);
        exp_b = bundle(1'b1, edst, m[2:0], vec, lvl, lvl ? ast : 1'b1, bc);
        act_b = bundle(msg_valid, msg_dest, msg_mode, msg_vector, msg_level, msg_assert, msg_bcast);
        chk(act_b == exp_b, "R4 message fields", act_b, exp_b);
        chk(msg_dest == edst, "R5 broadcast destination", {24'h0, msg_dest}, {24'h0, edst});
        chk(msg_assert == (lvl ? ast : 1'b1), "R6 assert semantics", {31'h0, msg_assert}, {31'h0, lvl ? ast : 1'b1});
        rd(LO, r); chk(r == (fields | 32'h1000), "R3 low readback while pending", r, fields | 32'h1000);
        chk(r[12] == 1'b1, "R9 status set while pending", {31'h0, r[12]}, 1);
        for (int k = 0; k < dly; k++) begin
          if (k == 0) wr(HI, {~dst, 24'h0}); else @(negedge clk);
          act_b = bundle(msg_valid, msg_dest, msg_mode, msg_vector, msg_level, msg_assert, msg_bcast);
          chk(act_b == exp_b, "R7 R4 hold without ready", act_b, exp_b);
        end
        msg_ready = 1;
        @(negedge clk);
        msg_ready = 0;
        chk(!msg_valid, "R7 valid drops after handshake", {31'h0, msg_valid}, 0);
        rd(LO, r); chk(r == fields, "R9 status clear after delivery", r, fields);
        chk(!cmd_err, "R8 no error on idle sends", {31'h0, cmd_err}, 0);
      end
    end

    wr(HI, 32'h2200_0000);
    wr(LO, 32'h0000_C512);
    wr(LO, 32'h0008_0634);
    chk(cmd_err, "R8 error latched on busy write", {31'h0, cmd_err}, 1);
    exp_b = bundle(1'b1, 8'h22, 3'b101, 8'h12, 1'b1, 1'b1, 1'b0);
    act_b = bundle(msg_valid, msg_dest, msg_mode, msg_vector, msg_level, msg_assert, msg_bcast);
    chk(act_b == exp_b, "R8 pending message unchanged", act_b, exp_b);
    rd(LO, r); chk(r == 32'h0000_D512, "R8 readback unchanged", r, 32'h0000_D512);
    msg_ready = 1; @(negedge clk); msg_ready = 0;
    chk(cmd_err && !msg_valid, "R8 error sticky after delivery", {msg_valid, cmd_err}, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule